// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the command half of an SD host controller. Software reaches it through a small memory-mapped register interface. The block holds a command word, a command argument, a host configuration word, a debug-mode word, an 11-bit status word and four 32-bit response words. When software writes a command word with the start bit set, the block sends one request to an abstract card-side port: a one-cycle request strobe with a 6-bit command index and a 32-bit argument. It then waits for the card to answer with a one-cycle response-valid pulse. That pulse carries an error flag, a byte count and up to sixteen response bytes.

When the answer arrives, the block checks the byte count against what the command word asked for. It packs the bytes into response words, sets completion or error status and drives one interrupt line. Response byte `i` is presented on `card_rsp_data[8*i +: 8]`. Serial line signalling, checksum generation, clock division, timeouts and the data path are left to other blocks.

Register reads are registered. Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled, and `reg_rdata` is 0 in cycles that follow no read.

Top module: `sdh_cmd_unit`

## Requirements
- R1: After reset, the following all read as 0: the command word, the argument, the configuration, the status, all four response words, `irq` and `card_req`. The debug-mode word reads 0x0000C60F.
- R2: The register offsets are: command 0x00, argument 0x04, response words 0 to 3 at 0x10, 0x14, 0x18 and 0x1C, status 0x20, debug mode 0x34, configuration 0x38. Argument and configuration read back what was last written. Reads of any other offset return 0.
- R3: The command word fields are: bit 15 start, bit 14 fail, bit 11 busy-wait, bit 10 no-response, bit 9 long-response, bits 5:0 index. A command write made while no command is outstanding stores the word and always reads back bit 15 as 0. If bit 15 was written as 1, `card_req` is high for exactly one cycle, in the cycle after the write, with `card_idx` equal to bits 5:0 and `card_arg` equal to the argument register.
- R4: On success of a command that expects a response and returns 4 bytes, response word 0 is {byte0, byte1, byte2, byte3}, with byte0 in bits 31:24. Words 1 to 3 become 0.
- R5: On success of a command that expects a response and returns 16 bytes, the words are stored in reversed order, each most significant byte first. Word 0 is {byte12..byte15}, word 1 is {byte8..byte11}, word 2 is {byte4..byte7} and word 3 is {byte0..byte3}.
- R6: A command fails in these cases. The card flags an error. Or the command expects a response and any of these holds: the length is 0, the length is 4 while long-response was requested, or the length is neither 4 nor 16. On failure, command bit 14 and status bit 6 are set and the response words keep their old values. Bit 14 stays set until the command word is next written.
- R7: A command with no-response set leaves all response words unchanged. It fails only when the card flags an error, whatever the length.
- R8: A successful command with busy-wait set sets status bit 10, but only when configuration bit 10 is 1.
- R9: Writing the status register clears each status bit written as 1 and leaves the other bits unchanged.
- R10: `irq` is high exactly when any of status bits 10, 9 or 8 is set. It changes in the same cycle as the status word.
- R11: A debug-mode write whose low nibble is 0xF stores the low nibble as 0. Any other value is stored unchanged.
- R12: A command-word write made while a command is outstanding is ignored. No request is issued, and the stored command word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, any of status bits 10:8 |
| card_req | output | 1 | One-cycle command request to the card port |
| card_idx | output | IDX_W | Command index of the request |
| card_arg | output | 32 | Command argument of the request |
| card_rsp_valid | input | 1 | One-cycle response pulse from the card port |
| card_rsp_err | input | 1 | Card reports a command error |
| card_rsp_len | input | LEN_W | Number of response bytes returned |
| card_rsp_data | input | 8*RSP_BYTES | Response bytes, byte i at bits 8*i+7:8*i |

## Verification
The bench builds the block with its default parameters: a 6-bit index, a 5-bit length field and a 16-byte response. With a 5-bit length, every length from 0 to 20 can be swept. That sweep runs against each combination of the long-response and no-response flags, with the card error flag raised on a fixed subset of lengths. Expected response words, fail bits and status are computed arithmetically from the byte pattern. A second sweep covers busy-wait against the enable bit and the error flag, and follows each case with partial and full write-1-to-clear. Directed cases cover the register map, the debug nibble rule and command writes made while a command is outstanding.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_CMD  = 8'h00;
  localparam logic [REG_AW-1:0] OFF_ARG  = 8'h04;
  localparam logic [REG_AW-1:0] OFF_RSP0 = 8'h10;
  localparam logic [REG_AW-1:0] OFF_STAT = 8'h20;
  localparam logic [REG_AW-1:0] OFF_DBG  = 8'h34;
  localparam logic [REG_AW-1:0] OFF_CFG  = 8'h38;

  localparam int CMD_W     = 16;
  localparam int CB_START  = 15;
  localparam int CB_FAIL   = 14;
  localparam int CB_BUSY   = 11;
  localparam int CB_NORSP  = 10;
  localparam int CB_LONG   = 9;

  localparam int STAT_W    = 11;
  localparam int SB_TMO    = 6;
  localparam int SB_BUSY   = 10;
  localparam int SB_IRQ_LO = 8;
  localparam int SB_IRQ_HI = 10;

  localparam int CFG_BUSYEN = 10;

  localparam logic [REG_DW-1:0] DBG_RESET = 32'h0000_C60F;
endpackage

// File: rtl/sdh_rsp_pack.sv
module sdh_rsp_pack #(
  parameter int RSP_BYTES = 16,
  parameter int LEN_W     = 5,
  localparam int NW       = RSP_BYTES / 4
) (
  input  logic [8*RSP_BYTES-1:0] bytes_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic                   err_i,
  input  logic                   long_i,
  input  logic                   no_rsp_i,
  output logic [32*NW-1:0]       words_o,
  output logic                   fail_o,
  output logic                   store_o
);
  logic is_short, is_full;
  assign is_short = (len_i == LEN_W'(4));
  assign is_full  = (len_i == LEN_W'(RSP_BYTES));

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int LB = (NW - 1 - w) * 4;
    logic [31:0] long_w, short_w;
    assign long_w = {bytes_i[8*LB +: 8], bytes_i[8*(LB+1) +: 8],
                     bytes_i[8*(LB+2) +: 8], bytes_i[8*(LB+3) +: 8]};
    if (w == 0) begin : g_first
      assign short_w = {bytes_i[7:0], bytes_i[15:8], bytes_i[23:16], bytes_i[31:24]};
    end else begin : g_rest
      assign short_w = '0;
    end
    assign words_o[32*w +: 32] = is_full ? long_w : short_w;
  end

  assign fail_o  = err_i | (!no_rsp_i & ((len_i == '0) | (is_short & long_i) |
                                         (!is_short & !is_full)));
  assign store_o = !fail_o & !no_rsp_i;
endmodule

// File: rtl/sdh_status_reg.sv
module sdh_status_reg
  import sdh_cmd_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_i,
  input  logic          clr_wr_i,
  input  logic [SW-1:0] clr_i,
  output logic [SW-1:0] status_o,
  output logic          irq_o
);
  logic [SW-1:0] nxt;
  assign nxt = (status_o & ~(clr_wr_i ? clr_i : '0)) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= nxt;
      irq_o    <= |nxt[SB_IRQ_HI:SB_IRQ_LO];
    end
  end
endmodule

// File: rtl/sdh_cmd_unit.sv
module sdh_cmd_unit
  import sdh_cmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int LEN_W     = 5,
  parameter int RSP_BYTES = 16,
  localparam int NW       = RSP_BYTES / 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [REG_DW-1:0]      reg_wdata,
  output logic [REG_DW-1:0]      reg_rdata,
  output logic                   irq,
  output logic                   card_req,
  output logic [IDX_W-1:0]       card_idx,
  output logic [REG_DW-1:0]      card_arg,
  input  logic                   card_rsp_valid,
  input  logic                   card_rsp_err,
  input  logic [LEN_W-1:0]       card_rsp_len,
  input  logic [8*RSP_BYTES-1:0] card_rsp_data
);
  logic [CMD_W-1:0]  cmd_q;
  logic [REG_DW-1:0] arg_q, cfg_q, dbg_q;
  logic [32*NW-1:0]  rsp_q, words;
  logic              pend_q, fail, store;
  logic [STAT_W-1:0] status, set_vec;
  logic              wr_cmd, done;
  logic [REG_DW-1:0] rd_mux;

  assign wr_cmd = reg_wr && (reg_addr == OFF_CMD) && !pend_q;
  assign done   = card_rsp_valid && pend_q;

  sdh_rsp_pack #(.RSP_BYTES(RSP_BYTES), .LEN_W(LEN_W)) u_pack (
    .bytes_i(card_rsp_data), .len_i(card_rsp_len), .err_i(card_rsp_err),
    .long_i(cmd_q[CB_LONG]), .no_rsp_i(cmd_q[CB_NORSP]),
    .words_o(words), .fail_o(fail), .store_o(store)
  );

  always_comb begin
    set_vec = '0;
    set_vec[SB_TMO]  = done && fail;
    set_vec[SB_BUSY] = done && !fail && cmd_q[CB_BUSY] && cfg_q[CFG_BUSYEN];
  end

  sdh_status_reg #(.SW(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .set_i(set_vec),
    .clr_wr_i(reg_wr && (reg_addr == OFF_STAT)),
    .clr_i(reg_wdata[STAT_W-1:0]),
    .status_o(status), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      arg_q    <= '0;
      cfg_q    <= '0;
      dbg_q    <= DBG_RESET;
      rsp_q    <= '0;
      pend_q   <= 1'b0;
      card_req <= 1'b0;
      card_idx <= '0;
      card_arg <= '0;
    end else begin
      card_req <= 1'b0;
      if (wr_cmd) begin
        cmd_q <= {1'b0, reg_wdata[CMD_W-2:0]};
        if (reg_wdata[CB_START]) begin
          pend_q   <= 1'b1;
          card_req <= 1'b1;
          card_idx <= reg_wdata[IDX_W-1:0];
          card_arg <= arg_q;
        end
      end
      if (done) begin
        pend_q <= 1'b0;
        if (fail)  cmd_q[CB_FAIL] <= 1'b1;
        if (store) rsp_q <= words;
      end
      if (reg_wr) begin
        if (reg_addr == OFF_ARG) arg_q <= reg_wdata;
        if (reg_addr == OFF_CFG) cfg_q <= reg_wdata;
        if (reg_addr == OFF_DBG)
          dbg_q <= (reg_wdata[3:0] == 4'hF) ? {reg_wdata[REG_DW-1:4], 4'h0} : reg_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFF_CMD:  rd_mux = REG_DW'(cmd_q);
      OFF_ARG:  rd_mux = arg_q;
      OFF_STAT: rd_mux = REG_DW'(status);
      OFF_DBG:  rd_mux = dbg_q;
      OFF_CFG:  rd_mux = cfg_q;
      default:  rd_mux = '0;
    endcase
    for (int k = 0; k < NW; k++)
      if (reg_addr == OFF_RSP0 + REG_AW'(4*k)) rd_mux = rsp_q[32*k +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/sdh_cmd_unit_chk.sv
module sdh_cmd_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        card_req,
  input logic [5:0]  card_idx,
  input logic        card_rsp_valid,
  input logic        card_rsp_err,
  input logic        irq,
  input logic        pend,
  input logic [10:0] stat,
  input logic [3:0]  dbg_lo
);
  logic evt;
  assign evt = card_rsp_valid && pend;

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    card_req |=> !card_req);

  assert_issue_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h00 && reg_wdata[15] && !pend)
      |=> (card_req && card_idx == $past(reg_wdata[5:0])));

  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h00 && pend) |=> !card_req);

  assert_fail_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (evt && card_rsp_err) |=> stat[6]);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h20 && reg_wdata[6] && !evt) |=> !stat[6]);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h20 && (&reg_wdata[10:8]) && !evt) |=> !irq);

  assert_dbg_nibble_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h34 && reg_wdata[3:0] == 4'hF) |=> (dbg_lo == 4'h0));
endmodule

bind sdh_cmd_unit sdh_cmd_unit_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .card_req(card_req), .card_idx(card_idx),
  .card_rsp_valid(card_rsp_valid), .card_rsp_err(card_rsp_err),
  .irq(irq), .pend(pend_q), .stat(status), .dbg_lo(dbg_q[3:0])
);

// File: tb/tb_sdh_cmd_unit.sv
module tb_sdh_cmd_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         reg_wr, reg_rd;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         irq, card_req;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic         card_rsp_valid, card_rsp_err;
  logic [4:0]   card_rsp_len;
  logic [127:0] card_rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_rsp [4];
  logic [31:0] rv;

  always #10 clk = ~clk;

  sdh_cmd_unit dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
    .card_rsp_valid(card_rsp_valid), .card_rsp_err(card_rsp_err),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic respond(input logic e, input logic [4:0] l, input logic [127:0] dat);
    @(negedge clk); card_rsp_valid = 1'b1; card_rsp_err = e;
    card_rsp_len = l; card_rsp_data = dat;
    @(negedge clk); card_rsp_valid = 1'b0;
  endtask

  function automatic logic [31:0] bw(input logic [127:0] d, input int b);
    return {d[8*b +: 8], d[8*(b+1) +: 8], d[8*(b+2) +: 8], d[8*(b+3) +: 8]};
  endfunction

  task automatic chk_rsp(input string req);
    for (int k = 0; k < 4; k++) begin
      rd(8'h10 + 8'(4*k), rv);
      chk(req, rv, m_rsp[k]);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] dat;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    card_rsp_valid = 0; card_rsp_err = 0; card_rsp_len = 0; card_rsp_data = 0;
    for (int k = 0; k < 4; k++) m_rsp[k] = 32'h0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 card_req", 32'(card_req), 0);
    rd(8'h00, rv); chk("R1 cmd", rv, 0);
    rd(8'h04, rv); chk("R1 arg", rv, 0);
    rd(8'h20, rv); chk("R1 status", rv, 0);
    rd(8'h34, rv); chk("R1 dbg", rv, 32'h0000C60F);
    rd(8'h38, rv); chk("R1 cfg", rv, 0);
    chk_rsp("R1 rsp");

    // R2 map
    wr(8'h38, 32'h0000_05A5); rd(8'h38, rv); chk("R2 cfg", rv, 32'h5A5);
    wr(8'h04, 32'hDEAD_BEEF); rd(8'h04, rv); chk("R2 arg", rv, 32'hDEADBEEF);
    rd(8'h2C, rv); chk("R2 unmapped", rv, 0);
    rd(8'h30, rv); chk("R2 unmapped", rv, 0);
    wr(8'h38, 32'h0);

    // R11 debug nibble
    wr(8'h34, 32'h1234_567F); rd(8'h34, rv); chk("R11 nibble", rv, 32'h12345670);
    wr(8'h34, 32'h0000_ABCD); rd(8'h34, rv); chk("R11 plain", rv, 32'h0000ABCD);

    // R3 write without start
    wr(8'h00, 32'h0000_0022);
    chk("R3 no req", 32'(card_req), 0);
    rd(8'h00, rv); chk("R3 store", rv, 32'h22);

    // R3..R7 sweep over flags and lengths
    for (int nr = 0; nr < 2; nr++)
      for (int lg = 0; lg < 2; lg++)
        for (int l = 0; l <= 20; l++) begin
          logic e, fl;
          logic [15:0] cw;
          string tag;
          e = ((l % 7) == 3);
          for (int i = 0; i < 16; i++) dat[8*i +: 8] = 8'(i*29 + l*7 + nr*3 + lg + 1);
          cw = 16'((nr << 10) | (lg << 9) | (l % 64));
          wr(8'h04, 32'hA500_0000 | 32'(l));
          wr(8'h00, 32'(cw) | 32'h8000);
          chk("R3 req", 32'(card_req), 1);
          chk("R3 idx", 32'(card_idx), 32'(l % 64));
          chk("R3 arg", card_arg, 32'hA500_0000 | 32'(l));
          respond(e, 5'(l), dat);
          fl = e || (nr == 0 && (l == 0 || (l == 4 && lg == 1) || (l != 4 && l != 16)));
          if (!fl && nr == 0) begin
            if (l == 16) for (int k = 0; k < 4; k++) m_rsp[k] = bw(dat, 12 - 4*k);
            else begin
              m_rsp[0] = bw(dat, 0);
              for (int k = 1; k < 4; k++) m_rsp[k] = 0;
            end
          end
          tag = fl ? "R6 rsp kept" : (nr != 0 ? "R7 rsp kept" : (l == 16 ? "R5 long" : "R4 short"));
          rd(8'h00, rv); chk("R6 cmd fail bit", rv, 32'(cw) | (fl ? 32'h4000 : 0));
          rd(8'h20, rv); chk("R6 status", rv, fl ? 32'h040 : 0);
          chk_rsp(tag);
          wr(8'h20, 32'h7FF);
        end

    // R8 R9 R10 busy-wait sweep
    for (int ce = 0; ce < 2; ce++)
      for (int e = 0; e < 2; e++) begin
        logic [31:0] es;
        wr(8'h38, ce ? 32'h400 : 0);
        wr(8'h00, 32'h880D);
        respond(e[0], 5'd4, dat);
        es = e ? 32'h040 : (ce ? 32'h400 : 0);
        chk("R10 irq", 32'(irq), (ce == 1 && e == 0) ? 1 : 0);
        rd(8'h20, rv); chk("R8 busy status", rv, es);
        wr(8'h20, 32'h040);
        rd(8'h20, rv); chk("R9 partial clear", rv, es & ~32'h040);
        chk("R10 irq kept", 32'(irq), (es[10]) ? 1 : 0);
        wr(8'h20, 32'h400);
        rd(8'h20, rv); chk("R9 full clear", rv, 0);
        chk("R10 irq low", 32'(irq), 0);
      end
    wr(8'h38, 0);

    // R12 command write while outstanding
    wr(8'h00, 32'h8005);
    chk("R12 first req", 32'(card_req), 1);
    wr(8'h00, 32'h8209);
    chk("R12 no req", 32'(card_req), 0);
    rd(8'h00, rv); chk("R12 cmd kept", rv, 32'h0005);
    for (int i = 0; i < 16; i++) dat[8*i +: 8] = 8'(255 - i*11);
    respond(1'b0, 5'd4, dat);
    m_rsp[0] = bw(dat, 0);
    for (int k = 1; k < 4; k++) m_rsp[k] = 0;
    chk_rsp("R12 completes");
    wr(8'h00, 32'h8007);
    chk("R12 idle again", 32'(card_req), 1);
    chk("R12 idx", 32'(card_idx), 7);
    respond(1'b0, 5'd4, dat);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule